// File: doc/BRIEF.md
# Cascaded Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt sources into three banks of 32: a primary bank, a secondary bank and a pin bank. Each bank has a sticky cause register and an enable mask. The pin bank does not reach the CPU by itself. It is folded into four summary bits of the secondary cause, one bit for each byte of the pin bank. A single CPU interrupt line is raised whenever any enabled primary or secondary cause bit is set.

Software works through a 32-bit register port with a write strobe and a combinational read path. A select register reports the enabled cause of whichever primary bank holds pending work, and carries a flag that marks the secondary bank. Beside the register path, the block computes a 7-bit vector for the winning source every cycle: the bank number goes in the top two bits and the bit index in the low five. The vector comes with a valid flag. An interrupt handler can therefore service a source without walking the cause registers.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: A source input that is high at a rising clock edge sets its cause bit at that edge. The bit stays set after the source drops, until software clears it. Source index s maps to bank s/32, bit s%32.
- R2: A write to a cause register clears each bit written as 0 and keeps each bit written as 1. A source that is active on the same edge sets its bit regardless of the write.
- R3: After reset all three mask registers read 0, all cause registers read 0, and the CPU interrupt line is low.
- R4: The CPU interrupt line is the OR of (cause AND mask) over the primary bank and the secondary bank. A cause bit whose mask bit is 0 does not raise the line.
- R5: Secondary cause bits 24..27 are not latched. Bit 24+k reads as the OR of (pin cause AND pin mask) over pin bits 8k..8k+7, for k = 0..3.
- R6: The select register (0x24) reads the enabled secondary cause with bit 30 forced to 1 when that enabled cause is nonzero. Otherwise it reads the enabled primary cause with bit 30 at 0.
- R7: The vector code is {bank[1:0], index[4:0]}, with bank 0 = primary, 1 = secondary, 2 = pin. The highest-numbered enabled bit of the chosen bank wins. Any enabled secondary bit beats the primary bank. An enabled summary bit (24..27) hands the choice to the enabled pin cause.
- R8: The vector valid flag is low, and the code is 0, whenever no enabled primary or secondary cause bit is set. The valid flag always equals the CPU interrupt line.
- R9: Bits 30 and 31 of the primary and secondary cause registers are reserved. They never set and always read 0. Reads from unmapped addresses return 0.
- R10: Address map on an 8-bit byte address: 0x04 primary cause, 0x0C secondary cause, 0x14 primary mask, 0x1C secondary mask, 0x24 select (read-only), 0x88 pin cause, 0x8C pin mask. Mask registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 96 | Level-sensitive interrupt sources, primary 0..31, secondary 32..63, pin 64..95 |
| bus_we | input | 1 | Register write strobe, acts at the rising edge |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | The vector code names a pending enabled source |
| vec_code | output | 7 | Winning source: bank in bits 6:5, index in bits 4:0 |

## Verification
The directed part of the bench targets the cascade. With a pin source pending, toggling the pin mask must make summary bit 26 appear and disappear, and the vector must move to bank 2 ahead of a lower secondary source. A design that latched the summary bits, or ignored the pin mask, would leave a stale secondary bit and a wrong vector. The clear-by-zero semantics are probed three ways: all-ones writes must keep the bits, zero writes must clear them, and a held source must win over a simultaneous clear. A design that treated the cause as write-one-to-clear, or let the write win, would lose or keep the wrong bits. Reserved bits 30 and 31 are driven hard, so a design that latched them would corrupt the select flag. Long random runs with sparse sources and random mask and clear writes then compare every read, the interrupt line and the vector against a bench model on every cycle.

// File: rtl/cascade_irq_pkg.sv
package cascade_irq_pkg;
   typedef enum logic [1:0] {
      BANK_PRI = 2'd0,
      BANK_SEC = 2'd1,
      BANK_PIN = 2'd2
   } bank_e;

   localparam logic [7:0] OFF_PRI_CAUSE = 8'h04;
   localparam logic [7:0] OFF_SEC_CAUSE = 8'h0C;
   localparam logic [7:0] OFF_PRI_MASK  = 8'h14;
   localparam logic [7:0] OFF_SEC_MASK  = 8'h1C;
   localparam logic [7:0] OFF_SELECT    = 8'h24;
   localparam logic [7:0] OFF_PIN_CAUSE = 8'h08;
   localparam logic [7:0] OFF_PIN_MASK  = 8'h0C;
endpackage

// File: rtl/cascade_irq_cause.sv
// Sticky cause register: clear-by-zero writes, source set has priority.
module cascade_irq_cause #(
   parameter int                  WIDTH = 32,
   parameter logic [WIDTH-1:0]    LIVE  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] cause
);
   logic [WIDTH-1:0] kept;

   always_comb begin
      kept = wr ? (cause & wdata) : cause;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause <= '0;
      else        cause <= (kept | lvl) & LIVE;
   end
endmodule

// File: rtl/cascade_irq_prio.sv
// Highest-set-bit encoder.
module cascade_irq_prio #(
   parameter int WIDTH = 32,
   localparam int IW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] req,
   output logic             any,
   output logic [IW-1:0]    idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (req[i]) idx = IW'(i);
      end
      any = |req;
   end
endmodule

// File: rtl/cascade_irq_vector.sv
// Bank choice, vector code and select-register word.
module cascade_irq_vector
   import cascade_irq_pkg::*;
#(
   parameter int               WIDTH   = 32,
   parameter int               SEL_BIT = 30,
   parameter logic [WIDTH-1:0] SUMMARY = '0,
   localparam int              IW      = $clog2(WIDTH),
   localparam int              CODE_W  = 2 + IW
) (
   input  logic [WIDTH-1:0]  pri_en,
   input  logic [WIDTH-1:0]  sec_en,
   input  logic [WIDTH-1:0]  pin_en,
   output logic              valid,
   output logic [CODE_W-1:0] code,
   output logic [WIDTH-1:0]  sel_word
);
   logic          pri_any, sec_any, pin_any;
   logic [IW-1:0] pri_idx, sec_idx, pin_idx;
   logic          sum_hit;

   cascade_irq_prio #(.WIDTH(WIDTH)) u_pri (.req(pri_en), .any(pri_any), .idx(pri_idx));
   cascade_irq_prio #(.WIDTH(WIDTH)) u_sec (.req(sec_en), .any(sec_any), .idx(sec_idx));
   cascade_irq_prio #(.WIDTH(WIDTH)) u_pin (.req(pin_en), .any(pin_any), .idx(pin_idx));

   always_comb begin
      sum_hit = |(sec_en & SUMMARY);
      valid   = 1'b0;
      code    = '0;
      sel_word = pri_en;
      if (sec_any) begin
         sel_word          = sec_en;
         sel_word[SEL_BIT] = 1'b1;
         valid             = 1'b1;
         if (sum_hit && pin_any) code = {BANK_PIN, pin_idx};
         else                    code = {BANK_SEC, sec_idx};
      end else if (pri_any) begin
         valid = 1'b1;
         code  = {BANK_PRI, pri_idx};
      end
   end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
   import cascade_irq_pkg::*;
#(
   parameter int          GROUP_W  = 32,
   parameter int          ADDR_W   = 8,
   parameter int          SUM_LSB  = 24,
   parameter int          NUM_SUM  = 4,
   parameter int          SEL_BIT  = 30,
   parameter logic [7:0]  PIN_BASE = 8'h80,
   localparam int         SRC_W    = 3 * GROUP_W,
   localparam int         IW       = $clog2(GROUP_W),
   localparam int         CODE_W   = 2 + IW,
   localparam int         SUM_SPAN = GROUP_W / NUM_SUM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_W-1:0]  src,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [GROUP_W-1:0] bus_wdata,
   output logic [GROUP_W-1:0] bus_rdata,
   output logic              cpu_irq,
   output logic              vec_valid,
   output logic [CODE_W-1:0] vec_code
);
   localparam logic [GROUP_W-1:0] RSV     = {GROUP_W{1'b1}} << SEL_BIT;
   localparam logic [GROUP_W-1:0] SUMMARY = ((GROUP_W'(1) << NUM_SUM) - 1) << SUM_LSB;
   localparam logic [GROUP_W-1:0] PRI_LIVE = ~RSV;
   localparam logic [GROUP_W-1:0] SEC_LIVE = ~(RSV | SUMMARY);
   localparam logic [ADDR_W-1:0]  A_PIN_CAUSE = ADDR_W'(PIN_BASE + OFF_PIN_CAUSE);
   localparam logic [ADDR_W-1:0]  A_PIN_MASK  = ADDR_W'(PIN_BASE + OFF_PIN_MASK);

   if (GROUP_W != 32) begin : g_bad_width
      $error("GROUP_W must be 32 for the 2+5 bit vector layout");
   end
   if (SUM_LSB + NUM_SUM > SEL_BIT) begin : g_bad_summary
      $error("summary bits overlap the select flag");
   end
   if (GROUP_W % NUM_SUM != 0) begin : g_bad_span
      $error("NUM_SUM must divide GROUP_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [GROUP_W-1:0] pri_cause, sec_latched, sec_cause, pin_cause;
   logic [GROUP_W-1:0] pri_mask, sec_mask, pin_mask;
   logic [GROUP_W-1:0] pri_en, sec_en, pin_en;
   logic [GROUP_W-1:0] sel_word;
   logic [NUM_SUM-1:0] pin_sum;

   logic wr_pri_c, wr_sec_c, wr_pin_c;
   assign wr_pri_c = bus_we && (bus_addr == ADDR_W'(OFF_PRI_CAUSE));
   assign wr_sec_c = bus_we && (bus_addr == ADDR_W'(OFF_SEC_CAUSE));
   assign wr_pin_c = bus_we && (bus_addr == A_PIN_CAUSE);

   cascade_irq_cause #(.WIDTH(GROUP_W), .LIVE(PRI_LIVE)) u_pri_cause (
      .clk(clk), .rst_n(rst_n), .lvl(src[0 +: GROUP_W]),
      .wr(wr_pri_c), .wdata(bus_wdata), .cause(pri_cause));

   cascade_irq_cause #(.WIDTH(GROUP_W), .LIVE(SEC_LIVE)) u_sec_cause (
      .clk(clk), .rst_n(rst_n), .lvl(src[GROUP_W +: GROUP_W]),
      .wr(wr_sec_c), .wdata(bus_wdata), .cause(sec_latched));

   cascade_irq_cause #(.WIDTH(GROUP_W), .LIVE({GROUP_W{1'b1}})) u_pin_cause (
      .clk(clk), .rst_n(rst_n), .lvl(src[2*GROUP_W +: GROUP_W]),
      .wr(wr_pin_c), .wdata(bus_wdata), .cause(pin_cause));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_mask <= '0;
         sec_mask <= '0;
         pin_mask <= '0;
      end else if (bus_we) begin
         if (bus_addr == ADDR_W'(OFF_PRI_MASK)) pri_mask <= bus_wdata;
         if (bus_addr == ADDR_W'(OFF_SEC_MASK)) sec_mask <= bus_wdata;
         if (bus_addr == A_PIN_MASK)            pin_mask <= bus_wdata;
      end
   end

   assign pin_en = pin_cause & pin_mask;

   for (genvar k = 0; k < NUM_SUM; k++) begin : g_sum
      assign pin_sum[k] = |pin_en[k*SUM_SPAN +: SUM_SPAN];
   end

   assign sec_cause = sec_latched | (GROUP_W'(pin_sum) << SUM_LSB);
   assign pri_en    = pri_cause & pri_mask;
   assign sec_en    = sec_cause & sec_mask;
   assign cpu_irq   = (|pri_en) | (|sec_en);

   cascade_irq_vector #(.WIDTH(GROUP_W), .SEL_BIT(SEL_BIT), .SUMMARY(SUMMARY)) u_vec (
      .pri_en(pri_en), .sec_en(sec_en), .pin_en(pin_en),
      .valid(vec_valid), .code(vec_code), .sel_word(sel_word));

   always_comb begin
      bus_rdata = '0;
      if      (bus_addr == ADDR_W'(OFF_PRI_CAUSE)) bus_rdata = pri_cause;
      else if (bus_addr == ADDR_W'(OFF_SEC_CAUSE)) bus_rdata = sec_cause;
      else if (bus_addr == ADDR_W'(OFF_PRI_MASK))  bus_rdata = pri_mask;
      else if (bus_addr == ADDR_W'(OFF_SEC_MASK))  bus_rdata = sec_mask;
      else if (bus_addr == ADDR_W'(OFF_SELECT))    bus_rdata = sel_word;
      else if (bus_addr == A_PIN_CAUSE)            bus_rdata = pin_cause;
      else if (bus_addr == A_PIN_MASK)             bus_rdata = pin_mask;
   end
endmodule

// File: rtl/cascade_irq_chk.sv
module cascade_irq_chk #(
   parameter int GROUP_W = 32,
   parameter int SEL_BIT = 30,
   parameter int CODE_W  = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic [GROUP_W-1:0] src_pri,
   input logic               bus_we,
   input logic               cpu_irq,
   input logic               vec_valid,
   input logic [CODE_W-1:0]  vec_code,
   input logic [GROUP_W-1:0] pri_cause,
   input logic [GROUP_W-1:0] sel_word
);
   localparam logic [GROUP_W-1:0] RSV = {GROUP_W{1'b1}} << SEL_BIT;

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R8: valid flag tracks the interrupt line
   a_r8_valid_is_irq: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid == cpu_irq);

   // R8: idle vector is zero
   a_r8_idle_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> (vec_code == '0));

   // R7: bank field never 3
   a_r7_bank_legal: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_code[CODE_W-1 -: 2] != 2'b11));

   // R6: select flag agrees with the vector bank
   a_r6_sel_flag: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (sel_word[SEL_BIT] == (vec_code[CODE_W-1 -: 2] != 2'b00)));

   // R1: without a write no primary cause bit drops
   a_r1_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(bus_we)) |-> ((pri_cause & $past(pri_cause)) == $past(pri_cause)));

   // R1, R9: every live active source is latched at the edge
   a_r1_source_sets: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((pri_cause & $past(src_pri) & ~RSV) == ($past(src_pri) & ~RSV)));

   // R9: reserved bits stay clear
   a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_cause & RSV) == '0);
endmodule

bind cascade_irq_ctrl cascade_irq_chk #(.GROUP_W(GROUP_W), .SEL_BIT(SEL_BIT), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_pri(src[GROUP_W-1:0]), .bus_we(bus_we),
   .cpu_irq(cpu_irq), .vec_valid(vec_valid), .vec_code(vec_code),
   .pri_cause(pri_cause), .sel_word(sel_word));

// File: tb/cascade_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_bench;
   localparam logic [31:0] RSV  = 32'hC000_0000;
   localparam logic [31:0] SUMM = 32'h0F00_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] src = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cpu_irq, vec_valid;
   logic [6:0]  vec_code;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] m_pc, m_sc, m_gc, m_pm, m_sm, m_gm;

   always #2.5 clk = ~clk;

   cascade_irq_ctrl u_cascade_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src(src), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq),
      .vec_valid(vec_valid), .vec_code(vec_code));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] top_bit(input logic [31:0] v);
      logic [4:0] r = '0;
      for (int i = 0; i < 32; i++) if (v[i]) r = 5'(i);
      return r;
   endfunction

   function automatic logic [31:0] exp_sec();
      logic [31:0] g = m_gc & m_gm;
      logic [31:0] r = m_sc;
      for (int k = 0; k < 4; k++) if (|g[8*k +: 8]) r[24+k] = 1'b1;
      return r;
   endfunction

   function automatic logic [7:0] exp_vec();
      logic [31:0] p = m_pc & m_pm;
      logic [31:0] s = exp_sec() & m_sm;
      logic [31:0] g = m_gc & m_gm;
      if (s != 0) begin
         if ((s & SUMM) != 0) return {1'b1, 2'd2, top_bit(g)};
         return {1'b1, 2'd1, top_bit(s)};
      end
      if (p != 0) return {1'b1, 2'd0, top_bit(p)};
      return 8'h00;
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      logic [31:0] s = exp_sec() & m_sm;
      case (a)
         8'h04: return m_pc;
         8'h0C: return exp_sec();
         8'h14: return m_pm;
         8'h1C: return m_sm;
         8'h24: return (s != 0) ? (s | 32'h4000_0000) : (m_pc & m_pm);
         8'h88: return m_gc;
         8'h8C: return m_gm;
         default: return 32'h0;
      endcase
   endfunction

   // One clock: drive at falling edge, compare state, model the rising edge.
   task automatic tick(input logic [95:0] s, input logic we, input logic [7:0] a, input logic [31:0] wd);
      logic [7:0] v;
      @(negedge clk);
      src = s; bus_we = we; bus_addr = a; bus_wdata = wd;
      #1;
      v = exp_vec();
      chk("R4 cpu_irq", {31'b0, cpu_irq}, {31'b0, v[7]});
      chk("R7 vector", {24'b0, vec_valid, vec_code}, {24'b0, v});
      if (!we) chk("R10 read", bus_rdata, exp_read(a));
      @(posedge clk);
      #0.5;
      if (we) begin
         case (a)
            8'h04: m_pc = m_pc & wd;
            8'h0C: m_sc = m_sc & wd;
            8'h88: m_gc = m_gc & wd;
            8'h14: m_pm = wd;
            8'h1C: m_sm = wd;
            8'h8C: m_gm = wd;
            default: ;
         endcase
      end
      m_pc = (m_pc | s[31:0]) & ~RSV;
      m_sc = (m_sc | s[63:32]) & ~(RSV | SUMM);
      m_gc = m_gc | s[95:64];
   endtask

   task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_we = 1'b0; bus_addr = a;
      #0.5;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic peek_vec(input logic [7:0] exp, input string tag);
      chk(tag, {24'b0, vec_valid, vec_code}, {24'b0, exp});
   endtask

   initial begin
      #(200000 * 5);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] addrs [8];
      void'($urandom(32'd2718));
      addrs = '{8'h04, 8'h0C, 8'h14, 8'h1C, 8'h24, 8'h88, 8'h8C, 8'h50};
      m_pc = 0; m_sc = 0; m_gc = 0; m_pm = 0; m_sm = 0; m_gm = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R3: reset state
      peek(8'h14, 0, "R3 primary mask");
      peek(8'h1C, 0, "R3 secondary mask");
      peek(8'h8C, 0, "R3 pin mask");
      peek(8'h04, 0, "R3 primary cause");
      chk("R3 cpu_irq", {31'b0, cpu_irq}, 0);
      chk("R8 idle valid", {31'b0, vec_valid}, 0);

      // R1: pulse latches, masked source stays quiet
      tick(96'(1) << 5, 0, 8'h00, 0);
      tick('0, 0, 8'h00, 0);
      peek(8'h04, 32'h20, "R1 sticky after pulse");
      chk("R4 masked quiet", {31'b0, cpu_irq}, 0);

      tick('0, 1, 8'h14, 32'hFFFF_FFFF);
      chk("R4 enabled raises", {31'b0, cpu_irq}, 1);
      peek_vec(8'h85, "R7 primary bit 5");
      peek(8'h24, 32'h20, "R6 select primary");

      tick(96'(1) << 40, 1, 8'h1C, 32'hFFFF_FFFF);
      peek_vec(8'hA8, "R7 secondary beats primary");
      peek(8'h24, 32'h4000_0100, "R6 select secondary flag");
      peek(8'h0C, 32'h100, "R10 secondary cause");

      tick('0, 1, 8'h04, 32'hFFFF_FFFF);
      peek(8'h04, 32'h20, "R2 ones keep");
      tick('0, 1, 8'h04, 32'h0);
      peek(8'h04, 32'h0, "R2 zeros clear");

      // R5: pin cascade
      tick(96'(1) << 81, 1, 8'h8C, 32'hFFFF_FFFF);
      peek(8'h0C, 32'h0400_0100, "R5 summary bit 26");
      peek_vec(8'hD1, "R7 pin bank wins");
      peek(8'h24, 32'h4400_0100, "R6 select with summary");
      tick('0, 1, 8'h8C, 32'h0);
      peek(8'h0C, 32'h100, "R5 summary follows pin mask");
      peek_vec(8'hA8, "R7 back to secondary");
      tick('0, 1, 8'h88, ~(32'h1 << 17));
      peek(8'h88, 32'h0, "R2 pin clear");
      tick('0, 1, 8'h1C, 32'h0);
      peek_vec(8'h00, "R8 nothing enabled");

      // R9: reserved bits and unmapped address
      tick((96'h3 << 30) | (96'h3 << 62), 0, 8'h00, 0);
      peek(8'h04, 32'h0, "R9 primary reserved");
      peek(8'h0C, 32'h100, "R9 secondary reserved");
      peek(8'h40, 32'h0, "R9 unmapped read");

      // R2: held source beats simultaneous clear
      tick(96'(1) << 3, 1, 8'h04, 32'h0);
      peek(8'h04, 32'h8, "R2 set wins");
      tick((96'(1) << 12) | 96'h2, 0, 8'h00, 0);
      peek_vec(8'h8C, "R7 highest bit wins");

      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic [95:0] s;
         logic we;
         logic [7:0] a;
         logic [31:0] wd;
         s = {$urandom & $urandom & $urandom & $urandom,
              $urandom & $urandom & $urandom & $urandom,
              $urandom & $urandom & $urandom & $urandom};
         if ($urandom_range(3) != 0) s = '0;
         we = ($urandom_range(9) < 3);
         a  = addrs[$urandom_range(7)];
         wd = (a == 8'h14 || a == 8'h1C || a == 8'h8C) ? ($urandom | $urandom) : $urandom;
         tick(s, we, a, wd);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule